// File: doc/BRIEF.md
# Circular Buffer Pointer Updater

This block advances an address pointer by a signed step and folds the result back into a circular buffer, so that a load/store unit can walk a ring of memory without software wrap checks. The buffer is described by two values: a 32-bit modifier word and a start-address word. The modifier word carries a signed length and a small signed alignment code.

Two ways of locating the buffer are supported. In the explicit mode, the start comes from the start-address input and the end is start plus length. In the aligned mode, the buffer is assumed to sit on a power-of-two boundary derived from the alignment code: the low bits of the current pointer are cleared to find the start, and the length is ORed in to find the end. The step may be positive or negative, and the result is corrected once in whichever direction it left the window.

The unit is one register stage deep: a request on `in_valid` produces the new pointer on the following clock. Memory access is not part of the block. The step is expected to be smaller in size than the buffer length, so one correction is enough.

Top module: `cbuf_ptr_update`

## Requirements
- R1: The alignment code K is bits 27:24 of the modifier read as a signed 4-bit number, and the length is bits 16:0 of the modifier read as a signed 17-bit number, sign-extended to 32 bits.
- R2: When K is 0 and the signed length is 4 or more (explicit mode), the window start is the start-address input and the window end is start plus length, modulo 2^32.
- R3: In every other case (aligned mode), the mask has its low K+2 bits set (no bits when K+2 is 0 or less), the window start is the pointer with the mask bits cleared, and the window end is the start ORed with the length.
- R4: The candidate pointer is the pointer plus the offset, modulo 2^32.
- R5: If the candidate is at or above the window end (unsigned), the result is the candidate minus the length.
- R6: If the candidate is below the window start (unsigned) and not at or above the end, the result is the candidate plus the length.
- R7: Otherwise the result is the candidate unchanged, including a candidate equal to the window start.
- R8: `out_valid` equals `in_valid` of the previous clock, and `ptr_out` takes the result one clock after an accepted request; with `in_valid` low, `ptr_out` keeps its value whatever the other inputs do.
- R9: While `rst_n` is low, `out_valid` is 0 and `ptr_out` is 0.
- R10: A modifier with K equal to 0 and length below 4 selects the aligned mode with a 2-bit mask, not the explicit mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe; also the clock enable of the result register |
| ptr_in | input | 32 | Current pointer |
| offset | input | 32 | Signed step added to the pointer |
| modifier | input | 32 | Buffer descriptor word: K at 27:24, length at 16:0 |
| start_addr | input | 32 | Buffer start used in explicit mode |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| ptr_out | output | 32 | Updated pointer |

## Verification
The hardest situations to reach are the ones where the two modes meet: a zero alignment code paired with a short or negative length, which silently falls into the aligned mode, and an explicit window whose end wraps past 2^32 so that the unsigned end lies below the start. Directed requests build modifier words for exactly those cases, plus candidates landing exactly on the start and on the end, and a long run of random pointers, steps and descriptors follows, each compared every clock against a behavioural model of the two modes.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;

  // Default field layout of the buffer descriptor word.
  localparam int unsigned CB_ADDR_W  = 32;
  localparam int unsigned CB_K_LSB   = 24;
  localparam int unsigned CB_K_W     = 4;
  localparam int unsigned CB_LEN_W   = 17;
  localparam int unsigned CB_MIN_LEN = 4;

  // How the window was located.
  typedef enum logic {
    WIN_EXPLICIT = 1'b0,
    WIN_ALIGNED  = 1'b1
  } win_mode_e;

endpackage

// File: rtl/cbuf_decode.sv
module cbuf_decode
  import cbuf_pkg::*;
#(
  parameter int unsigned ADDR_W  = CB_ADDR_W,
  parameter int unsigned K_LSB   = CB_K_LSB,
  parameter int unsigned K_W     = CB_K_W,
  parameter int unsigned LEN_W   = CB_LEN_W,
  parameter int unsigned MIN_LEN = CB_MIN_LEN
) (
  input  logic [ADDR_W-1:0] ptr,
  input  logic [ADDR_W-1:0] modifier,
  input  logic [ADDR_W-1:0] start_reg,
  output logic [ADDR_W-1:0] win_start,
  output logic [ADDR_W-1:0] win_end,
  output logic [ADDR_W-1:0] len_ext,
  output win_mode_e         mode
);

  localparam int unsigned EXT_W = ADDR_W - LEN_W;

  logic signed [K_W-1:0] k_code;
  int                    shift_amt;
  logic [ADDR_W-1:0]     low_mask;
  logic [ADDR_W-1:0]     aligned_start;
  logic                  unused_fields;

  assign k_code    = $signed(modifier[K_LSB +: K_W]);
  assign len_ext   = {{EXT_W{modifier[LEN_W-1]}}, modifier[LEN_W-1:0]};
  assign shift_amt = int'(k_code) + 2;

  // Bits of the descriptor that carry neither K nor the length.
  assign unused_fields = ^{modifier[ADDR_W-1:K_LSB+K_W], modifier[K_LSB-1:LEN_W]};

  // One mask bit per address bit: set below the shift amount.
  for (genvar gi = 0; gi < ADDR_W; gi++) begin : g_mask
    assign low_mask[gi] = (shift_amt > gi);
  end

  assign aligned_start = ptr & ~low_mask;

  always_comb begin
    if ((k_code == '0) && ($signed(len_ext) >= $signed(ADDR_W'(MIN_LEN)))) begin
      mode      = WIN_EXPLICIT;
      win_start = start_reg;
      win_end   = start_reg + len_ext;
    end else begin
      mode      = WIN_ALIGNED;
      win_start = aligned_start;
      win_end   = aligned_start | len_ext;
    end
  end

endmodule

// File: rtl/cbuf_wrap.sv
module cbuf_wrap
  import cbuf_pkg::*;
#(
  parameter int unsigned ADDR_W = CB_ADDR_W
) (
  input  logic [ADDR_W-1:0] ptr,
  input  logic [ADDR_W-1:0] offset,
  input  logic [ADDR_W-1:0] win_start,
  input  logic [ADDR_W-1:0] win_end,
  input  logic [ADDR_W-1:0] len_ext,
  output logic [ADDR_W-1:0] cand,
  output logic [ADDR_W-1:0] next_ptr
);

  logic past_end;
  logic before_start;

  assign cand         = ptr + offset;
  assign past_end     = (cand >= win_end);
  assign before_start = (cand < win_start);

  // The upper correction takes precedence over the lower one.
  always_comb begin
    if (past_end) begin
      next_ptr = cand - len_ext;
    end else if (before_start) begin
      next_ptr = cand + len_ext;
    end else begin
      next_ptr = cand;
    end
  end

endmodule

// File: rtl/cbuf_ptr_update.sv
module cbuf_ptr_update
  import cbuf_pkg::*;
#(
  parameter int unsigned ADDR_W  = CB_ADDR_W,
  parameter int unsigned K_LSB   = CB_K_LSB,
  parameter int unsigned K_W     = CB_K_W,
  parameter int unsigned LEN_W   = CB_LEN_W,
  parameter int unsigned MIN_LEN = CB_MIN_LEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] ptr_in,
  input  logic [ADDR_W-1:0] offset,
  input  logic [ADDR_W-1:0] modifier,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              out_valid,
  output logic [ADDR_W-1:0] ptr_out
);

  logic [ADDR_W-1:0] win_start;
  logic [ADDR_W-1:0] win_end;
  logic [ADDR_W-1:0] len_ext;
  logic [ADDR_W-1:0] cand;
  logic [ADDR_W-1:0] next_ptr;
  win_mode_e         win_mode;

  logic [ADDR_W-1:0] ptr_d;
  logic [ADDR_W-1:0] ptr_q;
  logic              vld_q;

  cbuf_decode #(
    .ADDR_W  (ADDR_W),
    .K_LSB   (K_LSB),
    .K_W     (K_W),
    .LEN_W   (LEN_W),
    .MIN_LEN (MIN_LEN)
  ) u_decode (
    .ptr       (ptr_in),
    .modifier  (modifier),
    .start_reg (start_addr),
    .win_start (win_start),
    .win_end   (win_end),
    .len_ext   (len_ext),
    .mode      (win_mode)
  );

  cbuf_wrap #(
    .ADDR_W (ADDR_W)
  ) u_wrap (
    .ptr       (ptr_in),
    .offset    (offset),
    .win_start (win_start),
    .win_end   (win_end),
    .len_ext   (len_ext),
    .cand      (cand),
    .next_ptr  (next_ptr)
  );

  // Next-state: result register is enabled by the request strobe.
  always_comb begin
    ptr_d = ptr_q;
    if (in_valid) begin
      ptr_d = next_ptr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      vld_q <= 1'b0;
    end else begin
      ptr_q <= ptr_d;
      vld_q <= in_valid;
    end
  end

  assign ptr_out   = ptr_q;
  assign out_valid = vld_q;

endmodule

// File: rtl/cbuf_ptr_update_chk.sv
module cbuf_ptr_update_chk
  import cbuf_pkg::*;
#(
  parameter int unsigned ADDR_W = CB_ADDR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [ADDR_W-1:0] ptr_in,
  input logic [ADDR_W-1:0] offset,
  input logic [ADDR_W-1:0] win_start,
  input logic [ADDR_W-1:0] win_end,
  input logic [ADDR_W-1:0] len_ext,
  input win_mode_e         win_mode,
  input logic              out_valid,
  input logic [ADDR_W-1:0] ptr_out
);

  // A request whose pointer is inside a non-wrapping explicit window,
  // with headroom on both sides and a step shorter than the length.
  logic contained_req;
  assign contained_req = in_valid && (win_mode == WIN_EXPLICIT)
                      && (win_end > win_start)
                      && (win_start >= len_ext)
                      && (({1'b0, win_end} + {1'b0, len_ext}) <= {1'b0, {ADDR_W{1'b1}}})
                      && (ptr_in >= win_start) && (ptr_in < win_end)
                      && ($signed(offset) < $signed(len_ext))
                      && ($signed(offset) > -$signed(len_ext));

  // R9: reset clears the outputs.
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r9_reset_outputs: assert (!out_valid && (ptr_out == '0));
    end
  end

  // R8: the result strobe trails the request by one clock.
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R8: without a request the pointer holds.
  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(ptr_out));

  // R5 / R6 / R7: a contained request lands back inside its window.
  a_r5_r6_stays_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    contained_req |=> ((ptr_out >= $past(win_start)) && (ptr_out < $past(win_end))));

endmodule

bind cbuf_ptr_update cbuf_ptr_update_chk #(
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .ptr_in    (ptr_in),
  .offset    (offset),
  .win_start (win_start),
  .win_end   (win_end),
  .len_ext   (len_ext),
  .win_mode  (win_mode),
  .out_valid (out_valid),
  .ptr_out   (ptr_out)
);

// File: tb/cbuf_ptr_update_tb.sv
module cbuf_ptr_update_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] ptr_in;
  logic [31:0] offset;
  logic [31:0] modifier;
  logic [31:0] start_addr;
  logic        out_valid;
  logic [31:0] ptr_out;

  int checks = 0;
  int errors = 0;

  logic        exp_valid = 1'b0;
  logic [31:0] exp_ptr   = 32'h0;
  string       prev_tag  = "R9 reset";

  cbuf_ptr_update u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .ptr_in     (ptr_in),
    .offset     (offset),
    .modifier   (modifier),
    .start_addr (start_addr),
    .out_valid  (out_valid),
    .ptr_out    (ptr_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // Behavioural reference of the requirements, in 64-bit integer arithmetic.
  function automatic logic [31:0] ref_update(input logic [31:0] p, input logic [31:0] o,
                                             input logic [31:0] m, input logic [31:0] s);
    longint k, len, st, en, cand, mask, lenw;
    k = longint'(m[27:24]);
    if (k > 7) k = k - 16;                              // R1
    len = longint'(m[16:0]);
    if (len >= 65536) len = len - 131072;               // R1
    lenw = len & 64'hFFFF_FFFF;
    if (k == 0 && len >= 4) begin                       // R2
      st = longint'(s);
      en = (st + lenw) % 64'h1_0000_0000;
    end else begin                                      // R3, R10
      mask = (k + 2 <= 0) ? 0 : ((64'd1 << (k + 2)) - 1);
      st = longint'(p) & ~mask & 64'hFFFF_FFFF;
      en = st | lenw;
    end
    cand = (longint'(p) + longint'(o)) % 64'h1_0000_0000; // R4
    if (cand >= en) return 32'(cand - lenw);            // R5
    else if (cand < st) return 32'(cand + lenw);        // R6
    else return 32'(cand);                              // R7
  endfunction

  function automatic logic [31:0] mkmod(input logic [3:0] k, input logic [16:0] len);
    return {4'h0, k, 7'h0, len};
  endfunction

  task automatic check_out(input string tag);
    checks++;
    if (out_valid !== exp_valid || ptr_out !== exp_ptr) begin
      errors++;
      $display("FAIL %s: valid=%0b ptr=%h expected valid=%0b ptr=%h",
               tag, out_valid, ptr_out, exp_valid, exp_ptr);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] p, input logic [31:0] o,
                      input logic [31:0] m, input logic [31:0] s, input string tag);
    @(negedge clk);
    check_out(prev_tag);
    in_valid   = v;
    ptr_in     = p;
    offset     = o;
    modifier   = m;
    start_addr = s;
    if (v) exp_ptr = ref_update(p, o, m, s);
    exp_valid = v;
    prev_tag  = tag;
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    in_valid   = 1'b1;
    ptr_in     = 32'h1234;
    offset     = 32'h4;
    modifier   = mkmod(4'h0, 17'h40);
    start_addr = 32'h1200;
    repeat (3) @(negedge clk);
    check_out("R9 outputs in reset despite request");
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // Explicit window 0x1000..0x1100.
    step(1, 32'h1010, 32'h20, mkmod(4'h0, 17'h100), 32'h1000, "R2 R7 inside window");
    step(1, 32'h10F0, 32'h20, mkmod(4'h0, 17'h100), 32'h1000, "R5 past end");
    step(1, 32'h10F0, 32'h10, mkmod(4'h0, 17'h100), 32'h1000, "R5 exactly at end");
    step(1, 32'h1008, -32'sd16, mkmod(4'h0, 17'h100), 32'h1000, "R6 below start");
    step(1, 32'h1010, -32'sd16, mkmod(4'h0, 17'h100), 32'h1000, "R7 exactly at start");
    step(1, 32'h2005, 32'h8, mkmod(4'h2, 17'd12), 32'hDEAD0000, "R3 aligned K=2");
    step(1, 32'h3001, 32'h2, mkmod(4'h0, 17'd3), 32'h9000, "R10 K=0 short length");
    step(1, 32'h0500, -32'sd4, mkmod(4'hD, 17'h10), 32'h0, "R3 K=-3 empty mask");
    step(1, 32'h0500, 32'h4, mkmod(4'hE, 17'h10), 32'h0, "R3 K=-2 empty mask");
    step(0, 32'hFFFF_0000, 32'h7777, mkmod(4'h3, 17'h5), 32'h55, "R8 hold idle 1");
    step(0, 32'h0, 32'h1, mkmod(4'h0, 17'h20), 32'h0, "R8 hold idle 2");
    step(1, 32'hFFFF_FFF0, 32'h20, mkmod(4'h0, 17'h100), 32'hFFFF_FF00, "R4 R2 end wraps 2^32");
    step(1, 32'h4003, 32'h1, mkmod(4'h0, 17'h1FFF0), 32'h4000, "R1 R10 negative length");
    step(1, 32'h8000_0010, 32'h8, mkmod(4'h7, 17'h180), 32'h0, "R3 K=7 large mask");
    step(1, 32'h0000_0100, 32'h8, mkmod(4'h8, 17'h20), 32'h0, "R1 K=-8");
    step(1, 32'h1234_5678, 32'h10, 32'hF0FE_0040 | mkmod(4'h0, 17'h40), 32'h1234_5640,
         "R1 stray descriptor bits ignored");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] rs, rl, rp, ro;
      logic [3:0]  rk;
      rk = ($urandom_range(0, 2) == 0) ? 4'($urandom) : 4'h0;
      rl = 32'($urandom_range(1, 4096));
      rs = $urandom & 32'hFFFF_F000;
      rp = rs + 32'($urandom_range(0, 4095));
      ro = ($urandom_range(0, 1) == 1) ? 32'($urandom_range(0, 4095)) : -32'($urandom_range(0, 4095));
      step($urandom_range(0, 4) != 0, rp, ro, mkmod(rk, rl[16:0]) | ($urandom & 32'hF0FE_0000),
           rs, "R5 R6 R7 R8 random");
    end

    step(0, 32'h0, 32'h0, 32'h0, 32'h0, "R8 final idle");
    @(negedge clk);
    check_out(prev_tag);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule